// File: doc/BRIEF.md
# Serial Receiver with Entry-Tagged Receive Queue

This block turns an asynchronous serial line into bytes and holds them in a short receive queue. A register interface reads the oldest byte. Each frame is one low start bit, eight data bits sent least significant bit first, an optional ninth slot bit and one stop bit. The slot bit is present when parity checking or extra-bit capture is switched on.

A free-running oversampling tick times the receiver, with sixteen ticks per bit period. A falling edge on the line starts a frame. The line is sampled again half a bit later to reject glitches, and every later bit is sampled at its middle. When the stop bit is sampled, the finished character is written into the queue together with its own parity-error bit and its captured extra bit. The flags on the outputs then describe the entry at the head of the queue: receive-pending, overrun and parity error. Software drains the queue with a pop strobe and clears the flags with separate strobes.

Top module: `serial_rx_queue`

## Requirements
- R1: The frame is read in this order: a start bit at 0, then 8 data bits least significant bit first, then the slot bit (present only when `par_en` or `xbit_en` is 1), then the stop bit. Each bit lasts 16 `tick` pulses and is sampled at its middle. The oldest stored byte appears on `rd_data`.
- R2: The queue holds 4 entries and gives them back in arrival order. `rd_pop` removes the oldest entry. A pop while the queue is empty has no effect.
- R3: A character that completes while the queue is full is discarded, and the stored entries stay unchanged. `ovr_flag` goes to 1 and stays at 1 until `clr_ovr` is pulsed.
- R4: With `par_en`=1 the slot bit is a parity bit. `par_odd`=0 selects even parity (data plus parity has an even count of ones) and `par_odd`=1 selects odd parity. A mismatch is stored with the entry. `perr_flag` goes to 1 while the head entry carries a mismatch. It stays at 1 until `clr_perr` is pulsed. A clear has no effect while the mismatched entry is still at the head.
- R5: `ri_flag` goes to 1 when a character is stored at the stop-bit sample. `clr_ri` is ignored while the queue holds any entry. It clears the flag only when the queue is empty.
- R6: `xbit_out` reports the captured bit of the head entry. With `xbit_en`=1 and `par_en`=0 it is the slot bit. With both at 0 it is the level of the stop bit. With `par_en`=1 it is the received parity bit.
- R7: While `rx_en`=0 no frame is received and any frame in progress is abandoned. Stored entries can still be read and popped.
- R8: A low pulse shorter than half a bit period is rejected as a glitch and stores nothing.
- R9: After reset the queue is empty and `ri_flag`, `ovr_flag` and `perr_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Asynchronous serial input line |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Parity checking on the slot bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| xbit_en | input | 1 | Capture the slot bit as an extra bit |
| rd_pop | input | 1 | Remove the oldest queue entry |
| clr_ri | input | 1 | Clear strobe for the receive-pending flag |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| clr_perr | input | 1 | Clear strobe for the parity-error flag |
| rd_data | output | 8 | Data byte of the oldest entry |
| ri_flag | output | 1 | Receive-pending flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| perr_flag | output | 1 | Sticky parity-error flag |
| xbit_out | output | 1 | Captured slot or stop bit of the oldest entry |

## Verification
The bench fills the queue and then sends a fifth frame. A design that overwrote an entry or let the write pointer wrap would show a changed head byte or the wrong order when the queue is drained. It strobes the receive-pending clear while entries remain and again after the last pop. A flag that cleared too early would drop an interrupt, and one that never cleared would hold it for good. Parity errors are placed on entries behind the head, and the parity-error clear is pulsed while a bad entry sits at the head. A design that tracked parity globally instead of per entry would raise the flag too early or lose it. A short low glitch and a frame sent with the receiver disabled must both leave the queue unchanged.

// File: rtl/srx_pkg.sv
// Shared types for the serial receive queue.
// Assumes: the character width is fixed here and used by every submodule.
package srx_pkg;
    localparam int DW = 8;

    // One queue entry: captured bit, parity mismatch, data byte.
    typedef struct packed {
        logic          xb;
        logic          pe;
        logic [DW-1:0] d;
    } srx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_SLOT,
        S_STOP
    } srx_state_t;
endpackage

// File: rtl/srx_sampler.sv
// Frame deserialiser: synchronises the line, finds the start bit,
// samples every bit at mid-period and emits one finished entry per frame.
// Assumes: tick is a single-cycle pulse, OSR ticks per bit, SYNC >= 2.
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       xbit_en,
    output logic       frm_valid,
    output srx_entry_t frm,
    output logic       busy
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);

    logic [SYNC-1:0] sync_q;
    logic            line;
    logic            prev_q;
    srx_state_t      state;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bitn;
    logic [DW-1:0]   shreg;
    logic            slot_q;
    logic            has_slot;

    assign line     = sync_q[SYNC-1];
    assign has_slot = par_en | xbit_en;
    assign busy     = (state != S_IDLE);

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC-2:0], rxd};
    end

    // Line level at the previous tick, used for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= line;
    end

    // Receive state machine, advanced once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            slot_q    <= 1'b0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (!rx_en) begin
                state <= S_IDLE;
                cnt   <= '0;
            end else if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (prev_q && !line) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt  <= '0;
                            bitn <= '0;
                            state <= line ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DW-1:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == LASTBIT)
                                state <= has_slot ? S_SLOT : S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_SLOT: begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            slot_q <= line;
                            state  <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            frm_valid <= 1'b1;
                            frm.d     <= shreg;
                            frm.xb    <= has_slot ? slot_q : line;
                            frm.pe    <= par_en & ((^shreg) ^ slot_q ^ par_odd);
                            state     <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/srx_fifo.sv
// Entry queue: stores finished frames in arrival order and presents the head.
// Assumes: the caller never pushes when full; a pop when empty is ignored here.
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  srx_entry_t                 wdata,
    input  logic                       pop,
    output srx_entry_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LASTIDX = AW'(DEPTH - 1);

    srx_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_pop;

    assign full   = (cnt == NW'(DEPTH));
    assign empty  = (cnt == '0);
    assign do_pop = pop & ~empty;
    assign head   = mem[rd_ptr];

    // Pointer and occupancy bookkeeping, with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == LASTIDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop) rd_ptr <= (rd_ptr == LASTIDX) ? '0 : rd_ptr + 1'b1;
            if (push && !do_pop)      cnt <= cnt + 1'b1;
            else if (!push && do_pop) cnt <= cnt - 1'b1;
        end
    end

    // Entry storage, one slot per generated register.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                mem[i] <= '0;
            else if (push && wr_ptr == AW'(i))         mem[i] <= wdata;
        end
    end
endmodule

// File: rtl/srx_flags.sv
// Status flags: receive-pending, sticky overrun and sticky parity error.
// Assumes: head_pe is meaningful only while the queue is not empty.
module srx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_valid,
    input  logic full,
    input  logic empty,
    input  logic head_pe,
    input  logic clr_ri,
    input  logic clr_ovr,
    input  logic clr_perr,
    output logic accept,
    output logic ri_flag,
    output logic ovr_flag,
    output logic perr_flag
);
    logic drop;

    assign accept = frm_valid & ~full;
    assign drop   = frm_valid & full;

    // Flag updates: set conditions win over clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ri_flag   <= 1'b0;
            ovr_flag  <= 1'b0;
            perr_flag <= 1'b0;
        end else begin
            ri_flag   <= accept | (ri_flag & ~(clr_ri & empty));
            ovr_flag  <= drop | (ovr_flag & ~clr_ovr);
            perr_flag <= (~empty & head_pe) | (perr_flag & ~clr_perr);
        end
    end
endmodule

// File: rtl/serial_rx_queue.sv
// Top level: deserialiser feeding a per-entry tagged queue with status flags.
// Assumes: tick comes from an external baud divider at OSR ticks per bit.
module serial_rx_queue
    import srx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OSR   = 16,
    parameter int SYNC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          rx_en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          xbit_en,
    input  logic          rd_pop,
    input  logic          clr_ri,
    input  logic          clr_ovr,
    input  logic          clr_perr,
    output logic [DW-1:0] rd_data,
    output logic          ri_flag,
    output logic          ovr_flag,
    output logic          perr_flag,
    output logic          xbit_out
);
    localparam int NW = $clog2(DEPTH + 1);

    logic          frm_valid;
    srx_entry_t    frm;
    logic          busy;
    srx_entry_t    head;
    logic [NW-1:0] cnt;
    logic          full;
    logic          empty;
    logic          accept;

    srx_sampler #(.OSR(OSR), .SYNC(SYNC)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .xbit_en(xbit_en),
        .frm_valid(frm_valid), .frm(frm), .busy(busy)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(accept), .wdata(frm), .pop(rd_pop),
        .head(head), .cnt(cnt), .full(full), .empty(empty)
    );

    srx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .full(full),
        .empty(empty), .head_pe(head.pe), .clr_ri(clr_ri), .clr_ovr(clr_ovr),
        .clr_perr(clr_perr), .accept(accept), .ri_flag(ri_flag),
        .ovr_flag(ovr_flag), .perr_flag(perr_flag)
    );

    assign rd_data  = head.d;
    assign xbit_out = head.xb;
endmodule

// File: rtl/srx_chk.sv
// Property checker for serial_rx_queue, attached by bind below.
module srx_chk #(
    parameter int DEPTH = 4,
    parameter int NW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          clr_ri,
    input logic          clr_ovr,
    input logic          clr_perr,
    input logic          ri_flag,
    input logic          ovr_flag,
    input logic          perr_flag,
    input logic [NW-1:0] cnt,
    input logic          accept,
    input logic          busy
);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= NW'(DEPTH));

    // R3
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr) |=> ovr_flag);

    // R4
    perr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !clr_perr) |=> perr_flag);

    // R5
    ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_flag && cnt != '0) |=> ri_flag);

    // R5
    ri_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ri_flag && cnt != '0));

    // R7
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !busy);
endmodule

bind serial_rx_queue srx_chk #(.DEPTH(DEPTH), .NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clr_ri(clr_ri),
    .clr_ovr(clr_ovr), .clr_perr(clr_perr), .ri_flag(ri_flag),
    .ovr_flag(ovr_flag), .perr_flag(perr_flag), .cnt(cnt),
    .accept(accept), .busy(busy)
);

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;
    localparam int BITCLK = 32;   // 16 ticks, one tick every 2 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic rxd = 1'b1;
    logic rx_en = 1'b1;
    logic par_en = 1'b0, par_odd = 1'b0, xbit_en = 1'b0;
    logic rd_pop = 1'b0, clr_ri = 1'b0, clr_ovr = 1'b0, clr_perr = 1'b0;
    logic [7:0] rd_data;
    logic ri_flag, ovr_flag, perr_flag, xbit_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state: entry = {xb, pe, data}
    logic [9:0] q [$];
    bit ri_m = 0, ovr_m = 0, perr_m = 0;

    serial_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .xbit_en(xbit_en),
        .rd_pop(rd_pop), .clr_ri(clr_ri), .clr_ovr(clr_ovr),
        .clr_perr(clr_perr), .rd_data(rd_data), .ri_flag(ri_flag),
        .ovr_flag(ovr_flag), .perr_flag(perr_flag), .xbit_out(xbit_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic bit head_pe();
        return (q.size() > 0) ? q[0][8] : 1'b0;
    endfunction

    function automatic logic exp_parity(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all();
        wait_clk(3);
        if (q.size() > 0) begin
            chk(rd_data == q[0][7:0], "R1 rd_data", rd_data, q[0][7:0]);
            chk(xbit_out == q[0][9], "R6 xbit_out", xbit_out, q[0][9]);
        end
        chk(ri_flag == ri_m, "R5 ri_flag", ri_flag, ri_m);
        chk(ovr_flag == ovr_m, "R3 ovr_flag", ovr_flag, ovr_m);
        chk(perr_flag == perr_m, "R4 perr_flag", perr_flag, perr_m);
    endtask

    // Send one frame; pe/odd/xe give the mode, flip corrupts parity,
    // xb is the extra bit, stopv the stop level.
    task automatic send(input logic [7:0] d, input bit pe, input bit odd,
                        input bit xe, input bit flip, input bit xb,
                        input bit stopv);
        logic slot;
        logic [9:0] ent;
        @(negedge clk);
        par_en = pe; par_odd = odd; xbit_en = xe;
        rxd = 1'b0; wait_clk(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; wait_clk(BITCLK);
        end
        slot = pe ? (exp_parity(d, odd) ^ flip) : xb;
        if (pe || xe) begin
            rxd = slot; wait_clk(BITCLK);
        end
        rxd = stopv; wait_clk(BITCLK);
        rxd = 1'b1; wait_clk(BITCLK / 2);
        if (rx_en) begin
            ent = {(pe || xe) ? slot : stopv, pe & flip, d};
            if (q.size() < 4) begin
                q.push_back(ent);
                ri_m = 1;
            end else begin
                ovr_m = 1;
            end
            perr_m = perr_m | head_pe();
        end
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (q.size() > 0) void'(q.pop_front());
        perr_m = perr_m | head_pe();
    endtask

    task automatic clear(input bit a, input bit b, input bit c);
        @(negedge clk);
        clr_ri = a; clr_ovr = b; clr_perr = c;
        @(negedge clk);
        clr_ri = 0; clr_ovr = 0; clr_perr = 0;
        if (a && q.size() == 0) ri_m = 0;
        if (b) ovr_m = 0;
        if (c) perr_m = 0;
        perr_m = perr_m | head_pe();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h1f2e3d4c);
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R9 reset state
        chk(ri_flag == 0 && ovr_flag == 0 && perr_flag == 0, "R9 reset flags",
            {ri_flag, ovr_flag, perr_flag}, 0);

        // R1 basic frame, R6 stop level captured
        send(8'hA5, 0, 0, 0, 0, 0, 1);
        check_all();
        // R6 stop bit low captured with no slot
        send(8'h3C, 0, 0, 0, 0, 0, 0);
        check_all();
        // R2 order, fill the queue, R3 overflow
        send(8'h01, 0, 0, 0, 0, 0, 1);
        send(8'hFE, 0, 0, 1, 0, 0, 1);   // R6 extra bit 0
        check_all();
        send(8'h77, 0, 0, 0, 0, 0, 1);   // fifth: discarded
        chk(ovr_flag == 1, "R3 overrun set", ovr_flag, 1);
        check_all();
        // R5 clear ignored while entries remain
        clear(1, 0, 0);
        chk(ri_flag == 1, "R5 clear ignored with data", ri_flag, 1);
        for (int i = 0; i < 4; i++) begin
            check_all();
            pop_one();
        end
        check_all();
        // R2 pop when empty ignored
        pop_one();
        check_all();
        chk(ri_flag == 1, "R5 flag held after drain", ri_flag, 1);
        clear(1, 1, 0);
        check_all();
        chk(ri_flag == 0, "R5 cleared when empty", ri_flag, 0);
        chk(ovr_flag == 0, "R3 cleared by strobe", ovr_flag, 0);

        // R4 good even parity, then bad odd parity behind it
        send(8'h96, 1, 0, 0, 0, 0, 1);
        send(8'h13, 1, 1, 0, 1, 0, 1);
        check_all();
        chk(perr_flag == 0, "R4 no error at good head", perr_flag, 0);
        pop_one();
        check_all();
        chk(perr_flag == 1, "R4 error at bad head", perr_flag, 1);
        clear(0, 0, 1);
        check_all();
        chk(perr_flag == 1, "R4 clear blocked by bad head", perr_flag, 1);
        pop_one();
        clear(1, 0, 1);
        check_all();

        // R7 disabled receiver ignores a frame, pop still works
        send(8'h5A, 0, 0, 0, 0, 0, 1);
        rx_en = 1'b0;
        send(8'hC3, 0, 0, 0, 0, 0, 1);
        check_all();
        chk(rd_data == 8'h5A, "R7 frame ignored when off", rd_data, 8'h5A);
        pop_one();
        check_all();
        rx_en = 1'b1;
        clear(1, 0, 0);
        check_all();

        // R8 short low glitch stores nothing
        @(negedge clk);
        rxd = 1'b0; wait_clk(12);
        rxd = 1'b1; wait_clk(BITCLK * 12);
        check_all();
        chk(ri_flag == 0, "R8 glitch rejected", ri_flag, 0);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            int op;
            op = $urandom % 6;
            if (op < 3) begin
                send(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 4) == 0, 1'($urandom), ($urandom % 5) != 0);
            end else if (op < 5) begin
                pop_one();
            end else begin
                clear(1'($urandom), 1'($urandom), 1'($urandom));
            end
            check_all();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule